// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Lockout

This block receives characters from an idle-high asynchronous serial line. A two-flop synchroniser cleans up the incoming line. A falling edge then starts a frame, and the receiver confirms the start bit half a bit later. After that it samples every following bit at its centre, counting an externally supplied tick that runs at sixteen times the bit rate. Data is assembled least significant bit first in a shift register. The character is 7 or 8 bits long and may carry an even or odd parity bit. It ends with one or two stop bits. The configuration inputs are captured when a start edge is accepted.

At the first stop bit the frame is judged. A clean frame is moved into the data register and raises the receive-full flag. A bad first stop bit raises the framing flag. A parity mismatch raises the parity flag. In both of these error cases the character is still copied into the data register, but the receive-full flag does not rise. If the receive-full flag is still set when a frame completes, the overrun flag rises and the data register keeps its old character. While any error flag is set, new start edges are ignored. Software reads the data register and clears each flag with its own one-cycle pulse. Two interrupt requests share one enable: one follows the receive-full flag, the other follows any error flag.

The controller has six states. IDLE waits for a start edge. START checks the start bit at its centre. DATA samples the data bits. PARITY samples the parity bit. STOP checks the first stop bit. STOP2 lets a second stop bit go by. The transitions are:
- IDLE to START on a falling edge when no error flag is set.
- START back to IDLE if the line is high at mid-bit (a false start).
- START to DATA if the line is still low at mid-bit.
- DATA to PARITY after the last data bit when parity is enabled, otherwise DATA to STOP.
- PARITY to STOP.
- STOP to STOP2 when two stop bits are configured, otherwise STOP to IDLE.
- STOP2 to IDLE.

Top module: `uart_rx_lock`

## Requirements
- R1: After reset, all four flags, both interrupt outputs and the 8-bit data output are 0.
- R2: A frame starts only on a high-to-low line edge. If the line is high again at the centre of the start bit (8 ticks after the edge), the receiver goes back to IDLE and nothing is received.
- R3: Data bits arrive least significant first. With `cfg_len7`=1 the character is 7 bits long and bit 7 of `rx_data` reads 0. With `cfg_len7`=0 it is 8 bits long.
- R4: When `cfg_par_en`=1, one parity bit follows the data. With `cfg_par_odd`=0 the data bits plus the parity bit must hold an even number of 1s. With `cfg_par_odd`=1 they must hold an odd number. Otherwise a parity error is reported.
- R5: A frame with no error, received while `full_flag`=0, loads `rx_data` and sets `full_flag`.
- R6: If the first stop bit is sampled 0, `frm_flag` is set, the character is loaded into `rx_data`, and `full_flag` stays 0. With `cfg_stop2`=1, the second stop bit is not checked.
- R7: A parity error sets `par_flag`, loads the character into `rx_data`, and leaves `full_flag` at 0.
- R8: If `full_flag` is 1 when a frame completes, `ovr_flag` is set and `rx_data` keeps its previous value.
- R9: While any of `ovr_flag`, `frm_flag` or `par_flag` is 1, whole frames on the line are ignored. Reception resumes after every error flag has been cleared.
- R10: `irq_rx` equals `full_flag` AND `irq_en`. `irq_err` equals (`ovr_flag` OR `frm_flag` OR `par_flag`) AND `irq_en`.
- R11: A one-cycle pulse on `clr_full`, `clr_ovr`, `clr_frm` or `clr_par` clears the matching flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rx_line | input | 1 | Serial input line, idle high |
| cfg_len7 | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| cfg_par_en | input | 1 | Enables the parity bit |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| cfg_stop2 | input | 1 | 1 selects two stop bits |
| irq_en | input | 1 | Enable shared by both interrupt requests |
| clr_full | input | 1 | Clears the receive-full flag |
| clr_ovr | input | 1 | Clears the overrun flag |
| clr_frm | input | 1 | Clears the framing flag |
| clr_par | input | 1 | Clears the parity flag |
| rx_data | output | 8 | Receive data register |
| full_flag | output | 1 | Receive-full flag |
| ovr_flag | output | 1 | Overrun error flag |
| frm_flag | output | 1 | Framing error flag |
| par_flag | output | 1 | Parity error flag |
| irq_rx | output | 1 | Receive interrupt request |
| irq_err | output | 1 | Error interrupt request |

## Verification
A bit counter or sample point that has drifted shows up within one frame as a shifted or corrupted value on `rx_data`. A wrong parity accumulator shows up within one frame as a spurious or missing `par_flag`. A controller that ignores the lockout loads a character that should have been dropped, and this is visible on the first frame sent while a flag is set. A wrong transfer policy shows up on the same clock that the flag rises: `rx_data` either changes during an overrun or stays stale after a framing or parity error.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_STOP2
    } rx_state_t;

    typedef struct packed {
        logic len7;
        logic par_en;
        logic par_odd;
        logic stop2;
    } rx_cfg_t;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_s,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '1;
            prev  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], line_in};
            prev  <= chain[STAGES-1];
        end
    end

    assign line_s = chain[STAGES-1];
    assign fall   = prev & ~chain[STAGES-1];

    AST_FALL_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        fall |-> $past(line_s)); // R2
endmodule

// File: rtl/uart_rx_fsm.sv
module uart_rx_fsm
    import uart_rx_pkg::*;
#(
    parameter int OS_RATE = 16,
    parameter int DW      = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          os_tick,
    input  logic          line_s,
    input  logic          fall,
    input  logic          lock,
    input  rx_cfg_t       cfg_in,
    output logic          done,
    output logic [DW-1:0] done_data,
    output logic          done_frm,
    output logic          done_par
);
    localparam int CW = $clog2(OS_RATE);
    localparam int IW = $clog2(DW + 1);
    localparam logic [CW-1:0] HALF = CW'(OS_RATE / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OS_RATE - 1);

    rx_state_t     state, nxt;
    rx_cfg_t       cfg;
    logic [CW-1:0] cnt;
    logic [IW-1:0] bit_idx;
    logic [IW-1:0] nbits;
    logic [DW-1:0] shreg;
    logic          par_acc;
    logic          par_bad;
    logic          at_mid;
    logic          at_end;

    assign at_mid = os_tick && (cnt == HALF);
    assign at_end = os_tick && (cnt == LAST);
    assign nbits  = cfg.len7 ? IW'(DW - 1) : IW'(DW);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (fall && !lock) nxt = ST_START;
            ST_START:  if (at_mid) nxt = line_s ? ST_IDLE : ST_DATA;
            ST_DATA:   if (at_end && (bit_idx == nbits - IW'(1)))
                           nxt = cfg.par_en ? ST_PARITY : ST_STOP;
            ST_PARITY: if (at_end) nxt = ST_STOP;
            ST_STOP:   if (at_end) nxt = cfg.stop2 ? ST_STOP2 : ST_IDLE;
            ST_STOP2:  if (at_end) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg       <= '0;
            cnt       <= '0;
            bit_idx   <= '0;
            shreg     <= '0;
            par_acc   <= 1'b0;
            par_bad   <= 1'b0;
            done      <= 1'b0;
            done_data <= '0;
            done_frm  <= 1'b0;
            done_par  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state != nxt || at_end) cnt <= '0;
            else if (os_tick)           cnt <= cnt + CW'(1);
            unique case (state)
                ST_IDLE: begin
                    if (nxt == ST_START) begin
                        cfg     <= cfg_in;
                        shreg   <= '0;
                        bit_idx <= '0;
                        par_acc <= 1'b0;
                        par_bad <= 1'b0;
                    end
                end
                ST_START: ;
                ST_DATA: begin
                    if (at_end) begin
                        shreg   <= {line_s, shreg[DW-1:1]};
                        par_acc <= par_acc ^ line_s;
                        bit_idx <= bit_idx + IW'(1);
                    end
                end
                ST_PARITY: begin
                    if (at_end) par_bad <= (par_acc ^ line_s) != cfg.par_odd;
                end
                ST_STOP: begin
                    if (at_end) begin
                        done      <= 1'b1;
                        done_frm  <= ~line_s;
                        done_par  <= cfg.par_en & par_bad;
                        done_data <= cfg.len7 ? {1'b0, shreg[DW-1:1]} : shreg;
                    end
                end
                ST_STOP2: ;
                default: ;
            endcase
        end
    end

    AST_LOCK_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && lock) |=> state == ST_IDLE); // R9
    AST_START_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_START) |-> $past(fall)); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done,
    input  logic [DW-1:0] done_data,
    input  logic          done_frm,
    input  logic          done_par,
    input  logic          clr_full,
    input  logic          clr_ovr,
    input  logic          clr_frm,
    input  logic          clr_par,
    output logic [DW-1:0] data_q,
    output logic          full_q,
    output logic          ovr_q,
    output logic          frm_q,
    output logic          par_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            full_q <= 1'b0;
            ovr_q  <= 1'b0;
            frm_q  <= 1'b0;
            par_q  <= 1'b0;
        end else begin
            if (clr_full) full_q <= 1'b0;
            if (clr_ovr)  ovr_q  <= 1'b0;
            if (clr_frm)  frm_q  <= 1'b0;
            if (clr_par)  par_q  <= 1'b0;
            if (done) begin
                if (full_q) begin
                    ovr_q <= 1'b1;
                end else begin
                    data_q <= done_data;
                    if (done_frm) frm_q <= 1'b1;
                    if (done_par) par_q <= 1'b1;
                    if (!done_frm && !done_par) full_q <= 1'b1;
                end
            end
        end
    end

    AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_q) |-> $stable(data_q)); // R8
    AST_ERR_NO_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (done_frm || done_par) && !full_q) |=> !full_q); // R7
    AST_FRM_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frm_q) |-> $past(done)); // R6
endmodule

// File: rtl/uart_rx_lock.sv
module uart_rx_lock
    import uart_rx_pkg::*;
#(
    parameter int OS_RATE = 16,
    parameter int DW      = 8,
    parameter int SYNC    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          os_tick,
    input  logic          rx_line,
    input  logic          cfg_len7,
    input  logic          cfg_par_en,
    input  logic          cfg_par_odd,
    input  logic          cfg_stop2,
    input  logic          irq_en,
    input  logic          clr_full,
    input  logic          clr_ovr,
    input  logic          clr_frm,
    input  logic          clr_par,
    output logic [DW-1:0] rx_data,
    output logic          full_flag,
    output logic          ovr_flag,
    output logic          frm_flag,
    output logic          par_flag,
    output logic          irq_rx,
    output logic          irq_err
);
    logic          line_s, fall, lock;
    logic          done, done_frm, done_par;
    logic [DW-1:0] done_data;
    rx_cfg_t       cfg;

    assign cfg  = '{len7: cfg_len7, par_en: cfg_par_en,
                    par_odd: cfg_par_odd, stop2: cfg_stop2};
    assign lock = ovr_flag | frm_flag | par_flag;

    uart_rx_sync #(.STAGES(SYNC)) u_sync (
        .clk(clk), .rst_n(rst_n), .line_in(rx_line),
        .line_s(line_s), .fall(fall)
    );

    uart_rx_fsm #(.OS_RATE(OS_RATE), .DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .line_s(line_s),
        .fall(fall), .lock(lock), .cfg_in(cfg), .done(done),
        .done_data(done_data), .done_frm(done_frm), .done_par(done_par)
    );

    uart_rx_status #(.DW(DW)) u_status (
        .clk(clk), .rst_n(rst_n), .done(done), .done_data(done_data),
        .done_frm(done_frm), .done_par(done_par), .clr_full(clr_full),
        .clr_ovr(clr_ovr), .clr_frm(clr_frm), .clr_par(clr_par),
        .data_q(rx_data), .full_q(full_flag), .ovr_q(ovr_flag),
        .frm_q(frm_flag), .par_q(par_flag)
    );

    assign irq_rx  = full_flag & irq_en;
    assign irq_err = lock & irq_en;

    AST_NO_LOAD_WHILE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lock) && lock && !$past(done)) |-> $stable(rx_data)); // R9
endmodule

// File: tb/uart_rx_lock_bench.sv
module uart_rx_lock_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rx_line = 1'b1;
    logic       cfg_len7 = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_stop2 = 1'b0;
    logic       irq_en = 1'b1;
    logic       clr_full = 1'b0, clr_ovr = 1'b0, clr_frm = 1'b0, clr_par = 1'b0;
    logic [7:0] rx_data;
    logic       full_flag, ovr_flag, frm_flag, par_flag, irq_rx, irq_err;
    int         n_checks = 0;
    int         n_fail = 0;

    always #10 clk = ~clk;

    uart_rx_lock u_uart_rx_lock (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_line(rx_line),
        .cfg_len7(cfg_len7), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_stop2(cfg_stop2), .irq_en(irq_en), .clr_full(clr_full),
        .clr_ovr(clr_ovr), .clr_frm(clr_frm), .clr_par(clr_par),
        .rx_data(rx_data), .full_flag(full_flag), .ovr_flag(ovr_flag),
        .frm_flag(frm_flag), .par_flag(par_flag), .irq_rx(irq_rx), .irq_err(irq_err)
    );

    initial begin
        int div = 0;
        forever begin
            @(negedge clk);
            os_tick = (div == 3);
            div = (div + 1) % 4;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_ticks(int n);
        int k = 0;
        while (k < n) begin
            @(posedge clk);
            if (os_tick) k++;
        end
        @(negedge clk);
    endtask

    task automatic line_bit(logic b);
        rx_line = b;
        wait_ticks(16);
    endtask

    task automatic clear(logic f, logic o, logic fr, logic p);
        @(negedge clk);
        clr_full = f; clr_ovr = o; clr_frm = fr; clr_par = p;
        @(negedge clk);
        clr_full = 0; clr_ovr = 0; clr_frm = 0; clr_par = 0;
    endtask

    task automatic send_frame(logic [7:0] d, logic l7, logic pen, logic podd,
                              logic s2, logic bad_par, logic stop1, logic stop2v);
        int   nb = l7 ? 7 : 8;
        int   ones = $countones(l7 ? (d & 8'h7F) : d);
        logic pbit = podd ? ~ones[0] : ones[0];
        @(negedge clk);
        cfg_len7 = l7; cfg_par_en = pen; cfg_par_odd = podd; cfg_stop2 = s2;
        line_bit(1'b0);
        for (int i = 0; i < nb; i++) line_bit(d[i]);
        if (pen) line_bit(pbit ^ bad_par);
        line_bit(stop1);
        if (s2) line_bit(stop2v);
        rx_line = 1'b1;
        wait_ticks(4);
    endtask

    task automatic t_reset;
        check("R1 data", rx_data, 0);
        check("R1 flags", {full_flag, ovr_flag, frm_flag, par_flag}, 0);
        check("R1 irqs", {irq_rx, irq_err}, 0);
    endtask

    task automatic t_basic;
        send_frame(8'hA5, 0, 0, 0, 0, 0, 1, 1);
        check("R3 R5 data 8N1", rx_data, 8'hA5);
        check("R5 full", full_flag, 1);
        check("R10 irq_rx", irq_rx, 1);
        check("R10 irq_err idle", irq_err, 0);
        clear(1, 0, 0, 0);
        check("R11 clr_full", full_flag, 0);
    endtask

    task automatic t_len7_even;
        send_frame(8'hB5, 1, 1, 0, 0, 0, 1, 1);
        check("R3 R4 7-bit even", rx_data, 8'h35);
        check("R4 no par err", {full_flag, par_flag}, 2'b10);
    endtask

    task automatic t_overrun_lock;
        send_frame(8'h11, 0, 0, 0, 0, 0, 1, 1);
        check("R8 ovr set", ovr_flag, 1);
        check("R8 data kept", rx_data, 8'h35);
        check("R10 irq_err", irq_err, 1);
        clear(1, 0, 0, 0);
        send_frame(8'h22, 0, 0, 0, 0, 0, 1, 1);
        check("R9 locked data", rx_data, 8'h35);
        check("R9 locked full", full_flag, 0);
        clear(0, 1, 0, 0);
        check("R11 clr_ovr", ovr_flag, 0);
        send_frame(8'h22, 0, 0, 0, 0, 0, 1, 1);
        check("R9 resumed", {rx_data, full_flag}, {8'h22, 1'b1});
        clear(1, 0, 0, 0);
    endtask

    task automatic t_parity_err;
        send_frame(8'h0F, 0, 1, 0, 0, 1, 1, 1);
        check("R7 par flag", par_flag, 1);
        check("R7 data loaded", rx_data, 8'h0F);
        check("R7 full clear", full_flag, 0);
        clear(0, 0, 0, 1);
        check("R11 clr_par", par_flag, 0);
    endtask

    task automatic t_framing;
        send_frame(8'h5A, 0, 0, 0, 0, 0, 0, 1);
        check("R6 frm flag", frm_flag, 1);
        check("R6 data loaded", rx_data, 8'h5A);
        check("R6 full clear", full_flag, 0);
        clear(0, 0, 1, 0);
        check("R11 clr_frm", frm_flag, 0);
    endtask

    task automatic t_stop2_odd;
        send_frame(8'h3C, 0, 1, 1, 1, 0, 1, 0);
        check("R6 second stop ignored", {frm_flag, par_flag}, 0);
        check("R4 odd parity ok", {rx_data, full_flag}, {8'h3C, 1'b1});
        clear(1, 0, 0, 0);
    endtask

    task automatic t_false_start;
        @(negedge clk);
        cfg_len7 = 0; cfg_par_en = 0; cfg_stop2 = 0;
        rx_line = 1'b0;
        wait_ticks(4);
        rx_line = 1'b1;
        wait_ticks(40);
        check("R2 false start", {full_flag, frm_flag, rx_data}, {2'b00, 8'h3C});
        irq_en = 1'b0;
        send_frame(8'h81, 0, 0, 0, 0, 0, 1, 1);
        check("R2 after glitch", rx_data, 8'h81);
        check("R10 irq gated", {full_flag, irq_rx}, 2'b10);
        irq_en = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        wait_ticks(20);
        t_basic;
        t_len7_even;
        t_overrun_lock;
        t_parity_err;
        t_framing;
        t_stop2_odd;
        t_false_start;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule